// File: doc/BRIEF.md
# Escalation Ping Timeout Monitor

This block sits at the receiving end of an escalation channel. It watches for the periodic ping requests that an upstream alert handler sends, and it raises an escalation when those pings stop. It stays passive after reset until the first ping shows up. From then on it counts the cycles since the most recent ping. When that count reaches the threshold and no new ping has arrived, the block asserts its escalation output. The output then stays asserted until reset.

The threshold is not programmable. It is fixed at elaboration from the sender's guaranteed worst-case ping period, which is: channel count × (wait steps + timeout steps) × 2^(ping counter width). That period is then multiplied by a safety margin, four by default. With the default parameters the threshold is 2^22 cycles, and the counter is 22 bits wide. Producing the pings, and acting on the escalation, are both left to neighbouring logic.

Top module: `ping_watchdog`

## Requirements
- R1: While reset (synchronous, active high) is held, and on the first cycle after it, `escalate_o` is 0 and the monitor is unarmed.
- R2: Before the first cycle with `ping_i` = 1 after reset, `escalate_o` stays 0, however many cycles pass.
- R3: Let the last ping be sampled at clock edge E. If no ping follows, `escalate_o` goes to 1 right after edge E+LIMIT, and not before.
- R4: Every cycle with `ping_i` = 1 restarts the window. The next possible escalation moves to LIMIT edges after that ping.
- R5: A ping sampled at the very edge where the window would expire (E+LIMIT) counts as on time. No escalation results.
- R6: Once `escalate_o` is 1 it stays 1 until reset. Later pings do not clear it.
- R7: A ping held high for several cycles counts as a ping on every one of those cycles. The window is measured from the last high cycle.
- R8: LIMIT = MARGIN × CHANNELS × (WAIT_STEPS + TIMEOUT_STEPS) × 2^PING_CNT_W. The internal count never exceeds LIMIT−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ping_i | input | 1 | Ping request seen on this channel, one cycle per ping |
| escalate_o | output | 1 | Sticky escalation request |

## Verification
The bench goes after four boundaries.

- Pre-arm silence: a design that armed at reset would escalate after a long quiet start.
- Exact expiry: an off-by-one in the count would raise `escalate_o` one cycle early or one cycle late.
- A ping on the expiry cycle: a design that gave the timeout priority over the ping would escalate there.
- Pings after a trip: a design without a sticky latch would drop `escalate_o` when they arrive.

A continuous multi-cycle ping and a second reset are also covered. They catch window arithmetic that counts from the first high cycle instead of the last, and arming state that survives reset.

// File: rtl/epm_pkg.sv
package epm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WATCH = 2'd1,
        PH_TRIP  = 2'd2
    } phase_e;

    // Worst-case sender period times safety margin.
    function automatic longint unsigned window_len(
        input int unsigned margin,
        input int unsigned chans,
        input int unsigned waits,
        input int unsigned touts,
        input int unsigned cnt_w
    );
        longint unsigned span;
        span = longint'(margin) * longint'(chans) * longint'(waits + touts);
        return span << cnt_w;
    endfunction

endpackage

// File: rtl/epm_window.sv
module epm_window #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == last_val);
endmodule

// File: rtl/epm_phase.sv
module epm_phase
    import epm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ping,
    input  logic   at_last,
    output phase_e phase,
    output logic   restart,
    output logic   advance
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        restart = 1'b0;
        advance = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (ping) begin
                    phase_d = PH_WATCH;
                    restart = 1'b1;
                end
            end
            PH_WATCH: begin
                if (ping) begin
                    restart = 1'b1;
                end else if (at_last) begin
                    phase_d = PH_TRIP;
                end else begin
                    advance = 1'b1;
                end
            end
            PH_TRIP: phase_d = PH_TRIP;
            default: phase_d = PH_TRIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/ping_watchdog.sv
module ping_watchdog
    import epm_pkg::*;
#(
    parameter int unsigned CHANNELS      = 4,
    parameter int unsigned PING_CNT_W    = 16,
    parameter int unsigned WAIT_STEPS    = 2,
    parameter int unsigned TIMEOUT_STEPS = 2,
    parameter int unsigned MARGIN        = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ping_i,
    output logic escalate_o
);
    localparam longint unsigned LIMIT =
        window_len(MARGIN, CHANNELS, WAIT_STEPS, TIMEOUT_STEPS, PING_CNT_W);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last, restart, advance;

    epm_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .ping    (ping_i),
        .at_last (at_last),
        .phase   (phase_q),
        .restart (restart),
        .advance (advance)
    );

    epm_window #(.CNT_W(CNT_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .advance  (advance),
        .last_val (LAST_VAL),
        .cnt      (cnt_q),
        .at_last  (at_last)
    );

    assign escalate_o = (phase_q == PH_TRIP);
endmodule

// File: rtl/epm_checker.sv
module epm_checker
    import epm_pkg::*;
#(
    parameter int              CNT_W = 22,
    parameter longint unsigned LIMIT = 64'd4194304
) (
    input logic             clk,
    input logic             rst,
    input logic             ping_i,
    input logic             escalate_o,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LASTC = CNT_W'(LIMIT - 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!escalate_o && phase == PH_IDLE));

    assert_stay_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !ping_i) |=> (phase == PH_IDLE && !escalate_o));

    assert_exact_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(escalate_o) |-> ($past(cnt) == LASTC && !$past(ping_i)));

    assert_ping_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (ping_i && !escalate_o) |=> (cnt == '0));

    assert_on_time_R5: assert property (@(posedge clk) disable iff (rst)
        (ping_i && !escalate_o) |=> !escalate_o);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        escalate_o |=> escalate_o);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= LASTC);
endmodule

bind ping_watchdog epm_checker #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ping_i     (ping_i),
    .escalate_o (escalate_o),
    .phase      (phase_q),
    .cnt        (cnt_q)
);

// File: tb/ping_watchdog_test.sv
`timescale 1ns/1ps
module ping_watchdog_test;
    // Small parameters: 4 * 2 * (1+1) * 2^2 = 64 cycles (R8)
    localparam int T_EXP = 4 * 2 * (1 + 1) * (1 << 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ping = 1'b0;
    logic escalate;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference
    bit m_armed;
    bit m_esc;
    int m_since;

    always #5 clk = ~clk;

    ping_watchdog #(
        .CHANNELS(2), .PING_CNT_W(2), .WAIT_STEPS(1),
        .TIMEOUT_STEPS(1), .MARGIN(4)
    ) uut (
        .clk(clk), .rst(rst), .ping_i(ping), .escalate_o(escalate)
    );

    task automatic check(input string tag, input bit exp);
        checks++;
        if (escalate !== exp) begin
            fails++;
            $display("FAIL %s: escalate_o actual=%b expected=%b at %0t",
                     tag, escalate, exp, $time);
        end
    endtask

    task automatic step(input bit p, input string tag);
        ping = p;
        @(posedge clk);
        if (!m_esc) begin
            if (p) begin
                m_armed = 1;
                m_since = 0;
            end else if (m_armed) begin
                m_since++;
                if (m_since >= T_EXP) m_esc = 1;
            end
        end
        @(negedge clk);
        check(tag, m_esc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ping = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", 1'b0);
        rst = 1'b0;
        m_armed = 0; m_esc = 0; m_since = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset", 1'b0);
    endtask

    initial begin
        do_reset();
        // R2: long silence before the first ping
        for (int i = 0; i < 5 * T_EXP; i++) step(1'b0, "R2 unarmed");
        // arm, then hit the expiry edge with a ping (R5)
        step(1'b1, "R4 arm");
        for (int i = 0; i < T_EXP - 1; i++) step(1'b0, "R4 window");
        step(1'b1, "R5 ping at expiry");
        // periodic pings well inside the window (R4)
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < T_EXP / 2; i++) step(1'b0, "R4 between pings");
            step(1'b1, "R4 restart");
        end
        // held ping (R7) then exact expiry (R3)
        for (int i = 0; i < 10; i++) step(1'b1, "R7 held ping");
        for (int i = 0; i < T_EXP - 1; i++) step(1'b0, "R3 before expiry");
        step(1'b0, "R3 expiry edge");
        // sticky (R6)
        for (int i = 0; i < 20; i++) step(i % 3 == 0, "R6 sticky");
        // second reset clears arming (R1, R2)
        do_reset();
        for (int i = 0; i < 2 * T_EXP; i++) step(1'b0, "R2 after second reset");
        step(1'b1, "R3 rearm");
        for (int i = 0; i < T_EXP; i++) step(1'b0, "R3 second expiry");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run incomplete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule